// File: doc/BRIEF.md
# Rank Decode and DRAM Address Mapper

This block turns a channel-local memory address into DRAM coordinates. It first finds which of four rank-interleave ranges holds the address. It then removes the rank interleave from the address, picks a target word for that range and way, and subtracts the target's offset to form the rank address. The target word also names the channel rank, which gives the DIMM number and the rank within that DIMM.

The rank address is then spread into row, column, bank and bank-group fields. The bit layout depends on three settings: the page policy (closed or open), fine-grain banking, and an optional XOR hash on the bank and bank-group bits. Range words, target words, the row and column widths and the policy flags are static register inputs. They must be held stable while a lookup is in flight.

A request is a one-cycle `start_i` pulse with the address. Two cycles later `done_o` pulses with the decoded fields, and `valid_o` shows whether a range matched. A new request can be accepted on every cycle.

Top module: `rank_dram_mapper`

## Requirements
- R1: `done_o` is high exactly two clock cycles after each cycle where `start_i` is high, and at no other time. A start is accepted on every cycle, including back-to-back.
- R2: A range word is valid when bit 31 is set. Its limit is `(word[11:1] << 29) | (2^29-1)`. Range i covers `prev..limit` inclusive, where `prev` is 0 for range 0 and otherwise the raw limit of range i-1. That limit counts even when range i-1 is invalid. The lowest-numbered matching range wins.
- R3: When no valid range matches, `done_o` pulses with `valid_o` low, and every field output (dimm, rank, rank address, row, column, bank, bank group) is zero.
- R4: The interleave shift s is 6 when `cfg_closed_page_i`=1 and 13 otherwise. The way count is `1 << word[29:28]`. The pre-offset rank address is `((ca>>s)/ways)<<s` OR the low s bits of ca. The way index is `(ca>>s) mod ways`. The target word for range r, way k is `cfg_targets_i[(r*8+k)*32 +: 32]`.
- R5: The target word's bits [15:2], shifted left by 26, are subtracted from the rank address modulo 2^ADDR_W. Bits [19:16] are the channel rank. `dimm_o` is the channel rank divided by 4, and `rank_o` is the channel rank mod 4.
- R6: Closed page: row bit i comes from rank-address bit 15,16,17,18,20,21,22,28,10,11,12,13,29,30,31,32,33,34 for i = 0..17.
- R7: Closed page: column bit i comes from rank-address bit 3,4,5,14,19,23,24,25,26,27 for i = 0..9, and column bit 10 is always 1.
- R8: Open page: row bit i comes from 14,15,16,20,28,21,22,23,24,25,26,27,29..34. Column bits come from 3..12, or from 3,4,5,7..13 when `cfg_fine_bank_i`=1. Column bit 10 is 0.
- R9: The bank is `{a[b1],a[b0]}`, XORed with `{a[x1],a[x0]}` when `cfg_bank_xor_i`=1. Closed page uses (b0,b1)=(8,9) and (x0,x1)=(22,28). Open page uses (18,19) and (22,23).
- R10: The bank group is built the same way. Closed page uses (6,7) and (20,21). Open page uses (6 if fine-grain, else 13; 17) and (20,21).
- R11: Row bits at or above `cfg_row_bits_i` are zero, and column bits 0..9 at or above `cfg_col_bits_i` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Lookup request pulse |
| chan_addr_i | input | ADDR_W | Channel-local address |
| cfg_closed_page_i | input | 1 | 1 = closed-page layout, 0 = open-page layout |
| cfg_fine_bank_i | input | 1 | Fine-grain bank layout select (open page) |
| cfg_bank_xor_i | input | 1 | Enable XOR hash on bank and bank group |
| cfg_row_bits_i | input | 5 | Number of row bits in use |
| cfg_col_bits_i | input | 4 | Number of column bits in use |
| cfg_ranges_i | input | NUM_RANGES*32 | Range words, range i at bits [i*32 +: 32] |
| cfg_targets_i | input | NUM_RANGES*MAX_WAYS*32 | Target words per range and way |
| done_o | output | 1 | Result strobe |
| valid_o | output | 1 | A range matched |
| dimm_o | output | 2 | DIMM number |
| rank_o | output | 2 | Rank within DIMM |
| rank_addr_o | output | ADDR_W | Rank address |
| row_o | output | 18 | Row |
| col_o | output | 11 | Column, bit 10 = auto-precharge |
| bank_o | output | 2 | Bank address |
| bank_group_o | output | 2 | Bank group |

## Verification
Assertions check several properties on every cycle: the two-cycle request-to-result timing in both directions, all-zero fields on a miss, the column bit 10 that follows the page policy, and row bits above the configured width. Only the bench scenarios can show that the right range is chosen and that the bit layouts and XOR hashes are correct. These scenarios include the gap left by an invalid range that still advances the lower bound, the inclusive lower bound, way selection, offset subtraction and the derived DIMM and rank numbers. The bench compares each result against a reference model written from the requirements.

// File: rtl/rdm_pkg.sv
package rdm_pkg;
  localparam int CFG_W        = 32;
  localparam int VALID_BIT    = 31;
  localparam int WAY_LSB      = 28;
  localparam int LIM_LSB      = 1;
  localparam int LIM_W        = 11;
  localparam int LIM_SHIFT    = 29;
  localparam int OFF_LSB      = 2;
  localparam int OFF_W        = 14;
  localparam int OFF_SHIFT    = 26;
  localparam int CRANK_LSB    = 16;
  localparam int CRANK_W      = 4;
  localparam int TGT_KEEP_W   = CRANK_LSB + CRANK_W - OFF_LSB;
  localparam int SHIFT_CLOSED = 6;
  localparam int SHIFT_OPEN   = 13;
  localparam int ROW_W        = 18;
  localparam int COL_DATA_W   = 10;
  localparam int COL_W        = COL_DATA_W + 1;
  localparam int ROW_CNT_W    = 5;
  localparam int COL_CNT_W    = 4;

  // Source bit of each row bit, closed-page layout
  function automatic int row_src_closed(input int i);
    case (i)
      0: return 15;  1: return 16;  2: return 17;  3: return 18;
      4: return 20;  5: return 21;  6: return 22;  7: return 28;
      8: return 10;  9: return 11; 10: return 12; 11: return 13;
      default: return 17 + i;
    endcase
  endfunction

  // Source bit of each row bit, open-page layout
  function automatic int row_src_open(input int i);
    case (i)
      0: return 14;  1: return 15;  2: return 16;  3: return 20;
      4: return 28;
      default: return (i < 12) ? 16 + i : 17 + i;
    endcase
  endfunction

  function automatic int col_src_closed(input int i);
    case (i)
      0: return 3;  1: return 4;  2: return 5;  3: return 14;
      4: return 19;
      default: return 18 + i;
    endcase
  endfunction

  function automatic int col_src_open(input int i);
    return 3 + i;
  endfunction

  function automatic int col_src_fine(input int i);
    return (i < 3) ? 3 + i : 4 + i;
  endfunction
endpackage

// File: rtl/rdm_range_search.sv
module rdm_range_search
  import rdm_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int NUM_RANGES = 4,
  parameter int WAY_SEL_W  = 2
) (
  input  logic [ADDR_W-1:0]           ca,
  input  logic                        closed_page,
  input  logic [NUM_RANGES*CFG_W-1:0] range_cfg,
  output logic                        hit,
  output logic [$clog2(NUM_RANGES)-1:0] sel,
  output logic [(1<<WAY_SEL_W)-2:0]   way_idx,
  output logic [ADDR_W-1:0]           rank_pre
);
  localparam int SEL_W = $clog2(NUM_RANGES);
  localparam int IDX_W = (1 << WAY_SEL_W) - 1;

  logic [ADDR_W-1:0]     lim [NUM_RANGES];
  logic [NUM_RANGES-1:0] match;

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_range
    logic [CFG_W-1:0]  w;
    logic [ADDR_W-1:0] lo;
    logic              unused_w;
    assign w        = range_cfg[g*CFG_W +: CFG_W];
    assign unused_w = ^{w[VALID_BIT-1], w[WAY_LSB-1:LIM_LSB+LIM_W], w[LIM_LSB-1:0]};
    assign lim[g]   = (ADDR_W'(w[LIM_LSB +: LIM_W]) << LIM_SHIFT)
                    | {{(ADDR_W-LIM_SHIFT){1'b0}}, {LIM_SHIFT{1'b1}}};
    if (g == 0) begin : g_first
      assign lo = '0;
    end else begin : g_next
      assign lo = lim[g-1];
    end
    assign match[g] = w[VALID_BIT] && (ca >= lo) && (ca <= lim[g]);
  end

  always_comb begin
    sel = '0;
    for (int i = NUM_RANGES - 1; i >= 0; i--) begin
      if (match[i]) sel = SEL_W'(i);
    end
  end
  assign hit = |match;

  logic [WAY_SEL_W-1:0] wsh;
  logic [3:0]           sh;
  logic [ADDR_W-1:0]    hi;

  always_comb begin
    wsh      = range_cfg[int'(sel)*CFG_W + WAY_LSB +: WAY_SEL_W];
    sh       = closed_page ? 4'(SHIFT_CLOSED) : 4'(SHIFT_OPEN);
    hi       = ca >> sh;
    way_idx  = hi[IDX_W-1:0] & ~({IDX_W{1'b1}} << wsh);
    rank_pre = ((hi >> wsh) << sh) | (ca & ~({ADDR_W{1'b1}} << sh));
  end
endmodule

// File: rtl/rdm_bit_scatter.sv
module rdm_bit_scatter
  import rdm_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic [ADDR_W-1:0]    ra,
  input  logic                 closed_page,
  input  logic                 fine_bank,
  input  logic                 bank_xor,
  input  logic [ROW_CNT_W-1:0] row_bits,
  input  logic [COL_CNT_W-1:0] col_bits,
  output logic [ROW_W-1:0]     row,
  output logic [COL_W-1:0]     col,
  output logic [1:0]           bank,
  output logic [1:0]           bank_group
);
  logic [ROW_W-1:0]      row_c, row_o, row_mask;
  logic [COL_DATA_W-1:0] col_c, col_o, col_f, col_mask, col_sel;
  logic                  unused_ra;

  assign unused_ra = ^{ra[2:0], ra[ADDR_W-1:35]};

  for (genvar g = 0; g < ROW_W; g++) begin : g_row
    localparam int SC = row_src_closed(g);
    localparam int SO = row_src_open(g);
    assign row_c[g]    = ra[SC];
    assign row_o[g]    = ra[SO];
    assign row_mask[g] = ROW_CNT_W'(g) < row_bits;
  end

  for (genvar g = 0; g < COL_DATA_W; g++) begin : g_col
    localparam int SC = col_src_closed(g);
    localparam int SO = col_src_open(g);
    localparam int SF = col_src_fine(g);
    assign col_c[g]    = ra[SC];
    assign col_o[g]    = ra[SO];
    assign col_f[g]    = ra[SF];
    assign col_mask[g] = COL_CNT_W'(g) < col_bits;
  end

  always_comb begin
    if (closed_page) begin
      col_sel    = col_c;
      bank       = {ra[9], ra[8]} ^ (bank_xor ? {ra[28], ra[22]} : 2'b00);
      bank_group = {ra[7], ra[6]} ^ (bank_xor ? {ra[21], ra[20]} : 2'b00);
    end else begin
      col_sel    = fine_bank ? col_f : col_o;
      bank       = {ra[19], ra[18]} ^ (bank_xor ? {ra[23], ra[22]} : 2'b00);
      bank_group = {ra[17], (fine_bank ? ra[6] : ra[13])}
                 ^ (bank_xor ? {ra[21], ra[20]} : 2'b00);
    end
    row = (closed_page ? row_c : row_o) & row_mask;
    col = {closed_page, col_sel & col_mask};
  end
endmodule

// File: rtl/rank_dram_mapper.sv
module rank_dram_mapper
  import rdm_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int NUM_RANGES = 4,
  parameter int WAY_SEL_W  = 2,
  localparam int MAX_WAYS  = 1 << ((1 << WAY_SEL_W) - 1)
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 start_i,
  input  logic [ADDR_W-1:0]                    chan_addr_i,
  input  logic                                 cfg_closed_page_i,
  input  logic                                 cfg_fine_bank_i,
  input  logic                                 cfg_bank_xor_i,
  input  logic [ROW_CNT_W-1:0]                 cfg_row_bits_i,
  input  logic [COL_CNT_W-1:0]                 cfg_col_bits_i,
  input  logic [NUM_RANGES*CFG_W-1:0]          cfg_ranges_i,
  input  logic [NUM_RANGES*MAX_WAYS*CFG_W-1:0] cfg_targets_i,
  output logic                                 done_o,
  output logic                                 valid_o,
  output logic [1:0]                           dimm_o,
  output logic [1:0]                           rank_o,
  output logic [ADDR_W-1:0]                    rank_addr_o,
  output logic [ROW_W-1:0]                     row_o,
  output logic [COL_W-1:0]                     col_o,
  output logic [1:0]                           bank_o,
  output logic [1:0]                           bank_group_o
);
  localparam int SEL_W = $clog2(NUM_RANGES);
  localparam int IDX_W = (1 << WAY_SEL_W) - 1;

  // Stage A: range search and interleave removal
  logic                  hit;
  logic [SEL_W-1:0]      sel;
  logic [IDX_W-1:0]      way_idx;
  logic [ADDR_W-1:0]     rank_pre;
  logic [CFG_W-1:0]      tgt;
  logic                  unused_tgt;

  rdm_range_search #(.ADDR_W(ADDR_W), .NUM_RANGES(NUM_RANGES), .WAY_SEL_W(WAY_SEL_W)) u_search (
    .ca(chan_addr_i), .closed_page(cfg_closed_page_i), .range_cfg(cfg_ranges_i),
    .hit(hit), .sel(sel), .way_idx(way_idx), .rank_pre(rank_pre)
  );

  assign tgt        = cfg_targets_i[(int'(sel)*MAX_WAYS + int'(way_idx))*CFG_W +: CFG_W];
  assign unused_tgt = ^{tgt[CFG_W-1:CRANK_LSB+CRANK_W], tgt[OFF_LSB-1:0]};

  logic                  va, hita, cla, fga, bxa;
  logic [ADDR_W-1:0]     prea;
  logic [TGT_KEEP_W-1:0] tgta;
  logic [ROW_CNT_W-1:0]  rba;
  logic [COL_CNT_W-1:0]  cba;

  always_ff @(posedge clk) begin
    if (rst) begin
      va <= 1'b0; hita <= 1'b0; cla <= 1'b0; fga <= 1'b0; bxa <= 1'b0;
      prea <= '0; tgta <= '0; rba <= '0; cba <= '0;
    end else begin
      va   <= start_i;
      hita <= hit;
      prea <= rank_pre;
      tgta <= tgt[OFF_LSB +: TGT_KEEP_W];
      cla  <= cfg_closed_page_i;
      fga  <= cfg_fine_bank_i;
      bxa  <= cfg_bank_xor_i;
      rba  <= cfg_row_bits_i;
      cba  <= cfg_col_bits_i;
    end
  end

  // Stage B: offset removal and bit scatter
  logic [ADDR_W-1:0]  ra;
  logic [CRANK_W-1:0] crank;
  logic [ROW_W-1:0]   row_n;
  logic [COL_W-1:0]   col_n;
  logic [1:0]         bank_n, bg_n;

  assign ra    = prea - (ADDR_W'(tgta[OFF_W-1:0]) << OFF_SHIFT);
  assign crank = tgta[CRANK_LSB-OFF_LSB +: CRANK_W];

  rdm_bit_scatter #(.ADDR_W(ADDR_W)) u_scatter (
    .ra(ra), .closed_page(cla), .fine_bank(fga), .bank_xor(bxa),
    .row_bits(rba), .col_bits(cba),
    .row(row_n), .col(col_n), .bank(bank_n), .bank_group(bg_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o <= 1'b0; valid_o <= 1'b0; dimm_o <= '0; rank_o <= '0;
      rank_addr_o <= '0; row_o <= '0; col_o <= '0; bank_o <= '0; bank_group_o <= '0;
    end else begin
      done_o  <= va;
      valid_o <= va & hita;
      if (va) begin
        dimm_o       <= hita ? crank[3:2] : 2'b00;
        rank_o       <= hita ? crank[1:0] : 2'b00;
        rank_addr_o  <= hita ? ra : '0;
        row_o        <= hita ? row_n : '0;
        col_o        <= hita ? col_n : '0;
        bank_o       <= hita ? bank_n : 2'b00;
        bank_group_o <= hita ? bg_n : 2'b00;
      end
    end
  end

  assert_done_latency_R1: assert property (@(posedge clk) disable iff (rst)
    start_i |-> ##2 done_o);

  assert_no_spurious_done_R1: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(start_i, 2));

  assert_miss_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (done_o && !valid_o) |-> (row_o == '0 && col_o == '0 && rank_addr_o == '0
                              && dimm_o == 2'b00 && rank_o == 2'b00
                              && bank_o == 2'b00 && bank_group_o == 2'b00));

  assert_autoprecharge_R7: assert property (@(posedge clk) disable iff (rst)
    (done_o && valid_o) |-> (col_o[COL_W-1] == $past(cfg_closed_page_i, 2)));

  assert_row_width_R11: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ((row_o >> $past(cfg_row_bits_i, 2)) == '0));
endmodule

// File: tb/test_rank_dram_mapper.sv
module test_rank_dram_mapper;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 40;
  localparam int NR = 4;
  localparam int NW = 8;
  localparam int WDOG = 20000;

  typedef struct packed {
    logic          valid;
    logic [1:0]    dimm;
    logic [1:0]    rank;
    logic [AW-1:0] ra;
    logic [17:0]   row;
    logic [10:0]   col;
    logic [1:0]    bank;
    logic [1:0]    bg;
  } res_t;

  localparam logic [31:0] RANGES [NR] = '{32'h8000_0002, 32'h0000_0004, 32'h9000_0008, 32'hA000_0010};
  localparam int CROW [18] = '{15,16,17,18,20,21,22,28,10,11,12,13,29,30,31,32,33,34};
  localparam int OROW [18] = '{14,15,16,20,28,21,22,23,24,25,26,27,29,30,31,32,33,34};
  localparam int CCOL [10] = '{3,4,5,14,19,23,24,25,26,27};
  localparam int OCOL [10] = '{3,4,5,6,7,8,9,10,11,12};
  localparam int FCOL [10] = '{3,4,5,7,8,9,10,11,12,13};

  // {addr, closed, fine, xor, row_bits, col_bits}
  localparam int NV = 12;
  localparam logic [51:0] VEC [NV] = '{
    {40'h00_1234_5678, 1'b1, 1'b0, 1'b0, 5'd18, 4'd10},
    {40'h00_3FFF_FFC0, 1'b0, 1'b0, 1'b1, 5'd16, 4'd10},
    {40'h00_2AAA_5555, 1'b0, 1'b1, 1'b1, 5'd17, 4'd10},
    {40'h00_5FFF_FFFF, 1'b1, 1'b0, 1'b1, 5'd18, 4'd10},
    {40'h00_6ABC_DEF0, 1'b1, 1'b0, 1'b0, 5'd18, 4'd9},
    {40'h00_9FFF_FFFF, 1'b0, 1'b0, 1'b0, 5'd14, 4'd10},
    {40'h00_A000_1234, 1'b0, 1'b1, 1'b0, 5'd18, 4'd10},
    {40'h01_1234_5678, 1'b1, 1'b1, 1'b1, 5'd15, 4'd10},
    {40'h01_1FFF_FFFF, 1'b0, 1'b0, 1'b1, 5'd18, 4'd7},
    {40'h00_4000_0000, 1'b1, 1'b0, 1'b0, 5'd18, 4'd10},
    {40'h01_2000_0000, 1'b0, 1'b0, 1'b0, 5'd18, 4'd10},
    {40'h00_7777_1357, 1'b0, 1'b1, 1'b0, 5'd18, 4'd10}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] addr = '0;
  logic cl = 1'b1, fg = 1'b0, bx = 1'b0;
  logic [4:0] rb = 5'd18;
  logic [3:0] cb = 4'd10;
  logic [NR*32-1:0] ranges;
  logic [NR*NW*32-1:0] targets;
  logic done, valid;
  logic [1:0] dimm, rank, bank, bg;
  logic [AW-1:0] ra;
  logic [17:0] row;
  logic [10:0] col;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rank_dram_mapper i_rank_dram_mapper (
    .clk(clk), .rst(rst), .start_i(start), .chan_addr_i(addr),
    .cfg_closed_page_i(cl), .cfg_fine_bank_i(fg), .cfg_bank_xor_i(bx),
    .cfg_row_bits_i(rb), .cfg_col_bits_i(cb),
    .cfg_ranges_i(ranges), .cfg_targets_i(targets),
    .done_o(done), .valid_o(valid), .dimm_o(dimm), .rank_o(rank),
    .rank_addr_o(ra), .row_o(row), .col_o(col), .bank_o(bank), .bank_group_o(bg)
  );

  function automatic logic [31:0] tgt_word(input int r, input int k);
    logic [3:0] cr = 4'((4*r + k + 1) & 15);
    return {12'd0, cr, 14'(r), 2'b00};
  endfunction

  function automatic res_t model(input logic [AW-1:0] ca, input logic c, input logic f,
                                 input logic x, input int rbits, input int cbits);
    res_t r = '0;
    logic [AW-1:0] prev = '0;
    logic [AW-1:0] lim, q, pre, a;
    logic [31:0] w, tw;
    int sel = -1;
    int sh, ways, k;
    for (int i = 0; i < NR; i++) begin
      w = RANGES[i];
      lim = ({29'd0, w[11:1]} << 29) | 40'h1FFF_FFFF;
      if (sel < 0 && w[31] && ca >= prev && ca <= lim) sel = i;
      prev = lim;
    end
    if (sel < 0) return r;
    w = RANGES[sel];
    sh = c ? 6 : 13;
    ways = 1 << w[29:28];
    q = ca >> sh;
    k = int'(q % AW'(ways));
    pre = ((q / AW'(ways)) << sh) | (ca & ((40'd1 << sh) - 40'd1));
    tw = tgt_word(sel, k);
    a = pre - ({26'd0, tw[15:2]} << 26);
    r.valid = 1'b1;
    r.dimm = tw[19:18];
    r.rank = tw[17:16];
    r.ra = a;
    for (int i = 0; i < 18; i++)
      if (i < rbits) r.row[i] = a[c ? CROW[i] : OROW[i]];
    for (int i = 0; i < 10; i++)
      if (i < cbits) r.col[i] = a[c ? CCOL[i] : (f ? FCOL[i] : OCOL[i])];
    r.col[10] = c;
    if (c) begin
      r.bank = {a[9], a[8]} ^ (x ? {a[28], a[22]} : 2'b00);
      r.bg   = {a[7], a[6]} ^ (x ? {a[21], a[20]} : 2'b00);
    end else begin
      r.bank = {a[19], a[18]} ^ (x ? {a[23], a[22]} : 2'b00);
      r.bg   = {a[17], (f ? a[6] : a[13])} ^ (x ? {a[21], a[20]} : 2'b00);
    end
    return r;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_res(input string req, input res_t e);
    chk(req, "done", 64'(done), 64'd1);
    chk(req, "valid", 64'(valid), 64'(e.valid));
    chk(req, "dimm", 64'(dimm), 64'(e.dimm));
    chk(req, "rank", 64'(rank), 64'(e.rank));
    chk(req, "rank_addr", 64'(ra), 64'(e.ra));
    chk(req, "row", 64'(row), 64'(e.row));
    chk(req, "col", 64'(col), 64'(e.col));
    chk(req, "bank", 64'(bank), 64'(e.bank));
    chk(req, "bank_group", 64'(bg), 64'(e.bg));
  endtask

  task automatic setup(input logic [AW-1:0] a, input logic c, input logic f, input logic x,
                       input logic [4:0] r, input logic [3:0] n);
    addr = a; cl = c; fg = f; bx = x; rb = r; cb = n;
  endtask

  // Issue one lookup at a falling edge; return after the result is visible
  task automatic lookup(input logic [AW-1:0] a, input logic c, input logic f, input logic x,
                        input logic [4:0] r, input logic [3:0] n);
    setup(a, c, f, x, r, n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1", "done_early", 64'(done), 64'd0);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    res_t e;
    ranges = {RANGES[3], RANGES[2], RANGES[1], RANGES[0]};
    for (int r = 0; r < NR; r++)
      for (int k = 0; k < NW; k++)
        targets[(r*NW + k)*32 +: 32] = tgt_word(r, k);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk("R1", "reset_done", 64'(done), 64'd0);
    chk("R3", "reset_valid", 64'(valid), 64'd0);
    chk("R3", "reset_row", 64'(row), 64'd0);

    // vector table against the reference model
    for (int v = 0; v < NV; v++) begin
      lookup(VEC[v][51:12], VEC[v][11], VEC[v][10], VEC[v][9], VEC[v][8:4], VEC[v][3:0]);
      e = model(VEC[v][51:12], VEC[v][11], VEC[v][10], VEC[v][9],
                int'(VEC[v][8:4]), int'(VEC[v][3:0]));
      chk_res("R2 R4 R5 R6 R8 R9 R10", e);
    end

    // R7: address zero, closed page -> column only the auto-precharge bit
    lookup(40'h0, 1'b1, 1'b0, 1'b0, 5'd18, 4'd10);
    chk("R7", "valid", 64'(valid), 64'd1);
    chk("R7", "col", 64'(col), 64'h400);
    chk("R5", "rank", 64'(rank), 64'd1);
    chk("R6", "row", 64'(row), 64'd0);

    // R2 R3: gap left by invalid range 1 (range 2 begins at 0x5FFFFFFF)
    lookup(40'h00_4000_0000, 1'b1, 1'b0, 1'b0, 5'd18, 4'd10);
    chk("R3", "valid", 64'(valid), 64'd0);
    chk("R3", "col", 64'(col), 64'd0);
    chk("R3", "rank_addr", 64'(ra), 64'd0);

    // R2: inclusive lower bound of range 2
    lookup(40'h00_5FFF_FFFF, 1'b1, 1'b0, 1'b0, 5'd18, 4'd10);
    chk("R2", "valid", 64'(valid), 64'd1);

    // R3: beyond last range
    lookup(40'hFF_FFFF_FFFF, 1'b0, 1'b0, 1'b0, 5'd18, 4'd10);
    chk("R3", "valid", 64'(valid), 64'd0);
    chk("R3", "row", 64'(row), 64'd0);

    // R4 R5: range 3, 4 ways, open page, way 2 -> channel rank 15, offset 3<<26
    lookup(40'h01_0000_4000, 1'b0, 1'b0, 1'b0, 5'd18, 4'd10);
    chk("R5", "dimm", 64'(dimm), 64'd3);
    chk("R5", "rank", 64'(rank), 64'd3);
    chk("R4", "rank_addr", 64'(ra), 64'h3400_0000);

    // R11 R9 R10: all-ones low address, narrow widths, XOR cancels bank bits
    lookup(40'h00_3FFF_FFFF, 1'b1, 1'b0, 1'b1, 5'd4, 4'd3);
    chk("R11", "row", 64'(row), 64'hF);
    chk("R11", "col", 64'(col), 64'h407);
    chk("R9", "bank", 64'(bank), 64'd0);
    chk("R10", "bank_group", 64'(bg), 64'd0);
    lookup(40'h00_3FFF_FFFF, 1'b1, 1'b0, 1'b0, 5'd4, 4'd3);
    chk("R9", "bank_noxor", 64'(bank), 64'd3);
    chk("R10", "bg_noxor", 64'(bg), 64'd3);

    // R1: back-to-back requests give consecutive results
    setup(40'h00_1234_5678, 1'b1, 1'b0, 1'b0, 5'd18, 4'd10);
    start = 1'b1;
    @(negedge clk);
    addr = 40'h00_4000_0000;
    @(negedge clk);
    start = 1'b0;
    e = model(40'h00_1234_5678, 1'b1, 1'b0, 1'b0, 18, 10);
    chk_res("R1", e);
    @(negedge clk);
    chk("R1", "second_done", 64'(done), 64'd1);
    chk("R1", "second_valid", 64'(valid), 64'd0);
    @(negedge clk);
    chk("R1", "idle_done", 64'(done), 64'd0);

    summary();
  end
endmodule